// File: doc/BRIEF.md
# Polled Bus Arbiter with Programmable Poll Order

This block decides which of several bus devices becomes master without any per-device grant wire. Every device contributes to one shared request line (a wired-OR). While that line is active, the arbiter broadcasts device addresses one per clock on a set of poll-address lines, taking them from a small programmable table. Each device compares the broadcast address with its own fixed address. The first requesting device whose address appears becomes the owner and raises the shared BUSY line. Polling then halts until the owner lets go.

A device's priority is the position of its address in the poll table. Software can reorder the table and shorten the part of it in use through a count register. Addresses with no device behind them, and devices that are not requesting, are simply polled past. When the active part of the table is used up with no match, polling wraps to the first entry and continues. After every release, polling restarts at the first entry. The table can only be written while the bus is completely quiet.

Arbiter states: `ST_IDLE` (no request), `ST_POLL` (broadcasting table entries), `ST_HOLD` (a device owns the bus). Transitions: IDLE→POLL on request (start); POLL→POLL advance or wrap when there is no match; POLL→HOLD when BUSY rises (capture); POLL→IDLE when the request vanishes (abandon); HOLD→POLL when BUSY falls while a request remains (restart); HOLD→IDLE when BUSY falls with no request left (release).

Top module: `poll_arbiter`

## Requirements
- R1: After reset `busy` is 0, `owner` is all zeros, `poll_valid` is 0 and `poll_addr` is 0.
- R2: `bus_req` is the OR of all bits of `dev_req`, with no clock delay.
- R3: When `bus_req` is seen in idle, the next cycle shows `poll_valid`=1 and table entry 0 on `poll_addr`. Each following cycle without a match shows the next entry.
- R4: Device i has address i. If device i is requesting while its address is polled and `busy` is 0, `owner` bit i and `busy` are 1 from the next cycle. A device whose address sits at table position k wins k+2 cycles after its request is driven from idle. At most one `owner` bit is ever set.
- R5: Among several requesting devices, the one whose address appears earliest in the table wins.
- R6: An address with no device behind it, or whose device is not requesting, costs exactly one poll cycle and never stalls polling.
- R7: While `busy` is 1, `poll_valid` is 0 and the owner keeps the bus as long as its `dev_req` bit stays 1. Dropping that bit clears its `owner` bit on the next clock.
- R8: After a release with requests still pending, polling restarts at entry 0. A device at position k wins k+3 cycles after the previous owner drops its request.
- R9: Only entries 0 to count-1 are polled. With no match, entry count-1 is followed by entry 0 indefinitely while `bus_req` stays 1.
- R10: Writes to the table (`seq_wr`) and to the count (`cnt_wr`) take effect only in a cycle where `bus_req` and `busy` are both 0. Otherwise they are dropped.
- R11: A count write of 0 or of more than SEQ_LEN is ignored.
- R12: Reset leaves table entry i holding address i (modulo 2^ADDR_W) and the count at SEQ_LEN.
- R13: If `bus_req` falls while polling with no owner, `poll_valid` is 0 from the next cycle. The next request starts again at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | NUM_DEV | Per-device internal request; device i has address i |
| seq_wr | input | 1 | Poll-table write strobe |
| seq_idx | input | IDX_W | Poll-table entry being written |
| seq_addr | input | ADDR_W | Device address stored in that entry |
| cnt_wr | input | 1 | Count register write strobe |
| cnt_val | input | CNT_W | New count of entries in use (1..SEQ_LEN) |
| bus_req | output | 1 | Shared wired-OR request line |
| poll_valid | output | 1 | Poll-address lines carry a live poll |
| poll_addr | output | ADDR_W | Broadcast device address (0 when not valid) |
| busy | output | 1 | Shared BUSY line: a device owns the bus |
| owner | output | NUM_DEV | One-hot current owner |

## Verification
The assertions assume that a device drops its request only to release the bus or to give up waiting. They also assume that configuration writes arrive as single-cycle strobes whose index is inside the table. The bench changes `dev_req`, `seq_wr` and `cnt_wr` only at falling edges. It programs the table only from idle, except in the scenario where writes are deliberately attempted during ownership. It keeps every table index below SEQ_LEN.

// File: rtl/poll_arb_pkg.sv
package poll_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_POLL = 2'd1,
        ST_HOLD = 2'd2
    } arb_state_e;

endpackage

// File: rtl/poll_seq_regs.sv
module poll_seq_regs #(
    parameter int SEQ_LEN = 8,
    parameter int ADDR_W  = 3,
    localparam int IDX_W  = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1,
    localparam int CNT_W  = $clog2(SEQ_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              busy,
    input  logic              seq_wr,
    input  logic [IDX_W-1:0]  seq_idx,
    input  logic [ADDR_W-1:0] seq_addr,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  cnt_q
);

    logic [ADDR_W-1:0] table_q [SEQ_LEN];
    logic              quiet;
    logic              cnt_ok;

    // writes only accepted when the bus is completely quiet
    assign quiet  = !bus_req && !busy;
    assign cnt_ok = (cnt_val != '0) && (cnt_val <= CNT_W'(SEQ_LEN));

    generate
        for (genvar e = 0; e < SEQ_LEN; e++) begin : g_entry
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    table_q[e] <= ADDR_W'(e);
                end else if (quiet && seq_wr && (seq_idx == IDX_W'(e))) begin
                    table_q[e] <= seq_addr;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(SEQ_LEN);
        end else if (quiet && cnt_wr && cnt_ok) begin
            cnt_q <= cnt_val;
        end
    end

    assign rd_addr = table_q[rd_idx];

    // R10
    cnt_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && (bus_req || busy)) |=> $stable(cnt_q));

    // R11
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) && (cnt_q <= CNT_W'(SEQ_LEN)));

endmodule

// File: rtl/poll_arb_fsm.sv
module poll_arb_fsm
    import poll_arb_pkg::*;
#(
    parameter int SEQ_LEN = 8,
    localparam int IDX_W  = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1,
    localparam int CNT_W  = $clog2(SEQ_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req,
    input  logic             busy,
    input  logic [CNT_W-1:0] cnt,
    output logic [IDX_W-1:0] ptr,
    output logic             poll_valid
);

    arb_state_e       state_q, state_d;
    logic [IDX_W-1:0] ptr_d;
    logic             at_last;

    assign at_last = ({1'b0, ptr} == (CNT_W + 1)'(cnt - 1'b1));

    // next-state and pointer logic
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr;
        unique case (state_q)
            ST_IDLE: begin
                ptr_d = '0;
                if (bus_req) begin
                    state_d = ST_POLL;
                end
            end
            ST_POLL: begin
                if (busy) begin
                    state_d = ST_HOLD;
                    ptr_d   = '0;
                end else if (!bus_req) begin
                    state_d = ST_IDLE;
                    ptr_d   = '0;
                end else if (at_last) begin
                    ptr_d   = '0;
                end else begin
                    ptr_d   = ptr + 1'b1;
                end
            end
            ST_HOLD: begin
                ptr_d = '0;
                if (!busy) begin
                    state_d = bus_req ? ST_POLL : ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                ptr_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr     <= '0;
        end else begin
            state_q <= state_d;
            ptr     <= ptr_d;
        end
    end

    // outputs
    always_comb begin
        poll_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: poll_valid = 1'b0;
            ST_POLL: poll_valid = !busy;
            ST_HOLD: poll_valid = 1'b0;
            default: poll_valid = 1'b0;
        endcase
    end

    // R7
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (state_q == ST_HOLD));

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state_q) == ST_HOLD) && (state_q == ST_POLL)) |-> (ptr == '0));

    // R9
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, ptr} < (CNT_W + 1)'(cnt)));

    // R13
    abandon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_POLL) && !bus_req && !busy) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/poll_dev_node.sv
module poll_dev_node #(
    parameter int ADDR_W  = 3,
    parameter int MY_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              poll_valid,
    input  logic [ADDR_W-1:0] poll_addr,
    input  logic              busy,
    output logic              own_q
);

    logic hit;

    assign hit = poll_valid && (poll_addr == ADDR_W'(MY_ADDR)) && req && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q <= 1'b0;
        end else if (!req) begin
            own_q <= 1'b0;
        end else if (hit) begin
            own_q <= 1'b1;
        end
    end

    // R4
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> own_q);

    // R7
    keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q && req) |=> own_q);

    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !own_q);

endmodule

// File: rtl/poll_arbiter.sv
module poll_arbiter #(
    parameter int NUM_DEV = 6,
    parameter int SEQ_LEN = 8,
    parameter int ADDR_W  = 3,
    localparam int IDX_W  = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1,
    localparam int CNT_W  = $clog2(SEQ_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DEV-1:0] dev_req,
    input  logic               seq_wr,
    input  logic [IDX_W-1:0]   seq_idx,
    input  logic [ADDR_W-1:0]  seq_addr,
    input  logic               cnt_wr,
    input  logic [CNT_W-1:0]   cnt_val,
    output logic               bus_req,
    output logic               poll_valid,
    output logic [ADDR_W-1:0]  poll_addr,
    output logic               busy,
    output logic [NUM_DEV-1:0] owner
);

    logic [IDX_W-1:0]  ptr;
    logic [ADDR_W-1:0] rd_addr;
    logic [CNT_W-1:0]  cnt;

    // shared wired-OR lines
    assign bus_req   = |dev_req;
    assign busy      = |owner;
    assign poll_addr = poll_valid ? rd_addr : '0;

    poll_seq_regs #(
        .SEQ_LEN (SEQ_LEN),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_req  (bus_req),
        .busy     (busy),
        .seq_wr   (seq_wr),
        .seq_idx  (seq_idx),
        .seq_addr (seq_addr),
        .cnt_wr   (cnt_wr),
        .cnt_val  (cnt_val),
        .rd_idx   (ptr),
        .rd_addr  (rd_addr),
        .cnt_q    (cnt)
    );

    poll_arb_fsm #(
        .SEQ_LEN (SEQ_LEN)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (bus_req),
        .busy       (busy),
        .cnt        (cnt),
        .ptr        (ptr),
        .poll_valid (poll_valid)
    );

    generate
        for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
            poll_dev_node #(
                .ADDR_W  (ADDR_W),
                .MY_ADDR (d)
            ) u_node (
                .clk        (clk),
                .rst_n      (rst_n),
                .req        (dev_req[d]),
                .poll_valid (poll_valid),
                .poll_addr  (poll_addr),
                .busy       (busy),
                .own_q      (owner[d])
            );
        end
    endgenerate

    // R4
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(owner));

    // R7
    quiet_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (poll_addr == '0));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!busy && !poll_valid));

endmodule

// File: tb/poll_arbiter_test.sv
module poll_arbiter_test;

    localparam int NUM_DEV = 6;
    localparam int SEQ_LEN = 8;
    localparam int ADDR_W  = 3;
    localparam int IDX_W   = 3;
    localparam int CNT_W   = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_DEV-1:0] dev_req = '0;
    logic               seq_wr = 1'b0;
    logic [IDX_W-1:0]   seq_idx = '0;
    logic [ADDR_W-1:0]  seq_addr = '0;
    logic               cnt_wr = 1'b0;
    logic [CNT_W-1:0]   cnt_val = '0;
    logic               bus_req, poll_valid, busy;
    logic [ADDR_W-1:0]  poll_addr;
    logic [NUM_DEV-1:0] owner;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    poll_arbiter #(.NUM_DEV(NUM_DEV), .SEQ_LEN(SEQ_LEN), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req),
        .seq_wr(seq_wr), .seq_idx(seq_idx), .seq_addr(seq_addr),
        .cnt_wr(cnt_wr), .cnt_val(cnt_val),
        .bus_req(bus_req), .poll_valid(poll_valid), .poll_addr(poll_addr),
        .busy(busy), .owner(owner)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic seq_write(input int idx, input int addr);
        seq_wr = 1'b1; seq_idx = IDX_W'(idx); seq_addr = ADDR_W'(addr);
        tick(1);
        seq_wr = 1'b0;
    endtask

    task automatic cnt_write(input int v);
        cnt_wr = 1'b1; cnt_val = CNT_W'(v);
        tick(1);
        cnt_wr = 1'b0;
    endtask

    // counts falling edges until owner equals exp (or limit reached -> -1)
    task automatic wait_owner(input logic [NUM_DEV-1:0] exp, input int lim, output int n);
        n = -1;
        for (int i = 1; i <= lim; i++) begin
            @(negedge clk);
            if (owner == exp) begin n = i; break; end
        end
    endtask

    task automatic release_all();
        dev_req = '0;
        tick(3);
    endtask

    task automatic t_reset();
        check("R1", "busy after reset", busy, 0);
        check("R1", "owner after reset", owner, 0);
        check("R1", "poll_valid after reset", poll_valid, 0);
        check("R1", "poll_addr after reset", poll_addr, 0);
        dev_req = 6'b000100; #1;
        check("R2", "bus_req follows dev_req", bus_req, 1);
        dev_req = '0; #1;
        check("R2", "bus_req low with no request", bus_req, 0);
        tick(1);
    endtask

    task automatic t_first_poll();
        dev_req = 6'b100000;
        for (int k = 0; k < 4; k++) begin
            tick(1);
            check("R3", "poll_valid while polling", poll_valid, 1);
            check("R3", "polled entry in order", poll_addr, k);
        end
        dev_req = '0;
        tick(1);
        check("R13", "poll_valid after request dropped", poll_valid, 0);
        dev_req = 6'b100000;
        tick(1);
        check("R13", "restart at entry 0", poll_addr, 0);
        release_all();
    endtask

    task automatic t_single_grant();
        int n;
        dev_req = 6'b001000;
        wait_owner(6'b001000, 20, n);
        check("R12", "latency of device 3 with reset table", n, 5);
        check("R4", "busy with owner", busy, 1);
        check("R7", "poll_valid while busy", poll_valid, 0);
        tick(4);
        check("R7", "owner held while requesting", owner, 6'b001000);
        dev_req = '0;
        tick(1);
        check("R7", "owner cleared on release", owner, 0);
        tick(2);
        check("R7", "idle after release", poll_valid, 0);
    endtask

    task automatic t_priority_restart();
        int n;
        seq_write(0, 5); seq_write(1, 2); seq_write(2, 7); seq_write(3, 0);
        dev_req = 6'b000101;
        wait_owner(6'b000100, 20, n);
        check("R5", "earliest entry wins (dev 2 at pos 1)", n, 3);
        dev_req = 6'b000001;
        wait_owner(6'b000001, 20, n);
        check("R8", "restart latency for dev 0 at pos 3", n, 6);
        check("R6", "absent address 7 skipped, dev 0 owns", owner, 6'b000001);
        release_all();
    endtask

    task automatic t_wrap_count();
        int exp_seq[3] = '{5, 2, 7};
        int n;
        cnt_write(3);
        dev_req = 6'b010000;
        for (int k = 0; k < 7; k++) begin
            tick(1);
            check("R9", "wrapped poll address", poll_addr, exp_seq[k % 3]);
        end
        check("R9", "no owner while unmatched", busy, 0);
        dev_req = '0; tick(2);
        cnt_write(0);
        cnt_write(9);
        dev_req = 6'b010000;
        tick(4);
        check("R11", "count unchanged after bad writes", poll_addr, 5);
        dev_req = '0; tick(2);
        cnt_write(8);
        dev_req = 6'b010000;
        wait_owner(6'b010000, 20, n);
        check("R9", "full count reaches dev 4 at pos 4", n, 6);
    endtask

    task automatic t_lock();
        int n;
        // dev 4 owns now
        seq_write(4, 1);
        cnt_write(2);
        dev_req = '0; tick(3);
        dev_req = 6'b010000;
        wait_owner(6'b010000, 20, n);
        check("R10", "writes during ownership dropped", n, 6);
        release_all();
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_first_poll();
        t_single_grant();
        t_priority_restart();
        t_wrap_count();
        t_lock();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule